// File: doc/BRIEF.md
# Warp Context Slot Allocator

This block decides whether a thread block may enter a compute core. The core keeps a fixed pool of warp context slots (64 by default), and each warp holds 32 threads. An admission request names a block and its thread count; the allocator turns the count into a warp count, rounding up. It then reserves that many slots in one step, or none at all. A block is only let in when every one of its warps can be resident together, so several blocks can share the core while none is ever split.

Each reserved slot is tagged with the owning block's ID. A completion naming that ID releases all of its slots in a single clock. A request that does not fit yet is held, with no slot taken, and is re-evaluated every clock until enough slots have been released. Requests for zero threads, or for more threads than a block may have (1024 by default), get a reject response.

The admission side is a valid/ready interface. `adm_ready` is high only while no request is held. A request is taken on a clock edge where `adm_valid` and `adm_ready` are both high. While a request waits for slots, `adm_ready` stays low and the source must hold off. The response is a one-cycle pulse with no back-pressure. Completions and the free-slot count are plain pins.

Top module: `warp_slot_alloc`

## Requirements
- R1: After reset, `free_count` equals the number of slots (64), `adm_ready` is 1 and `rsp_valid` is 0.
- R2: A request for T threads, with T from 1 to 1024, needs ceil(T/32) slots, and a granted `rsp_mask` has exactly that many bits set.
- R3: A grant happens only when all needed slots are free. Until then the request is held: `adm_ready` is 0, no response is given, and `free_count` does not fall because of it.
- R4: Granted slots are the lowest-numbered free slots. Bit i of `rsp_mask` stands for slot i.
- R5: A request with more than 1024 threads gets `rsp_valid`=1 with `rsp_grant`=0 and `rsp_mask`=0. No slot is taken.
- R6: A request with zero threads is rejected in the same way as in R5.
- R7: A completion with `cmp_valid`=1 frees every slot tagged with `cmp_id`. `free_count` shows the result in the next cycle.
- R8: A completion whose ID owns no slot changes nothing; `free_count` stays the same.
- R9: When a grant and a completion fall in the same cycle, the next `free_count` equals the old value minus the slots granted plus the slots released. Slots released in that cycle are not handed to that grant.
- R10: Several blocks can be resident at once, each holding its own disjoint set of slots.
- R11: If a request is accepted in cycle c, its response is visible in cycle c+2 for exactly one cycle, provided it can be decided at once. `adm_ready` is 1 again in that cycle.
- R12: A held request is retried every clock. It is granted in the cycle after the completion that frees enough slots takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adm_valid | input | 1 | Admission request present |
| adm_ready | output | 1 | Allocator can take a request |
| adm_id | input | ID_W (6) | ID of the block asking for entry |
| adm_threads | input | THR_W (12) | Thread count of that block |
| cmp_valid | input | 1 | Completion present this cycle |
| cmp_id | input | ID_W (6) | ID of the block that finished |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_grant | output | 1 | 1 = admitted, 0 = rejected |
| rsp_mask | output | NUM_SLOTS (64) | Slots reserved by the grant |
| free_count | output | CNT_W (7) | Slots currently free |

## Verification
A grant for a held request and a completion can happen in the same clock. They act on the same slot map and on the same free counter. The bench provokes this in two ways. First, it raises `cmp_valid` in the cycle right after an admission handshake, when the request is being decided. Second, it frees slots while a large request is held. The result is judged by the returned mask and by the counter. The mask must avoid the slots being released that cycle. The counter must reflect both the grant and the release on the next edge. A behavioural model of the slot pool, updated on every edge, states the expected outputs in every cycle.

// File: rtl/warp_alloc_pkg.sv
package warp_alloc_pkg;

  // Outcome of evaluating the held request in one cycle
  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_WAIT   = 2'd1,
    DEC_GRANT  = 2'd2,
    DEC_REJECT = 2'd3
  } alloc_dec_e;

endpackage

// File: rtl/warp_slot_table.sv
// Slot occupancy and owner tags; release by ID match over all slots at once.
module warp_slot_table #(
  parameter int NUM_SLOTS = 64,
  parameter int ID_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [NUM_SLOTS-1:0] set_mask,
  input  logic [ID_W-1:0]      set_id,
  input  logic                 clr_en,
  input  logic [ID_W-1:0]      clr_id,
  output logic [NUM_SLOTS-1:0] busy,
  output logic [NUM_SLOTS-1:0] clr_hit
);

  logic [NUM_SLOTS-1:0] busy_q;
  logic [ID_W-1:0]      owner_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // release acts only on slots occupied at the start of the cycle
    assign clr_hit[s] = clr_en && busy_q[s] && (owner_q[s] == clr_id);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[s]  <= 1'b0;
        owner_q[s] <= '0;
      end else begin
        if (set_en && set_mask[s]) begin
          busy_q[s]  <= 1'b1;
          owner_q[s] <= set_id;
        end else if (clr_hit[s]) begin
          busy_q[s]  <= 1'b0;
        end
      end
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/warp_slot_picker.sv
// Lowest-index-first selection of `need` slots out of a free map.
module warp_slot_picker #(
  parameter int NUM_SLOTS = 64,
  parameter int NEED_W    = 13,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int CMP_W    = (NEED_W > CNT_W) ? NEED_W : CNT_W
) (
  input  logic [NUM_SLOTS-1:0] free_map,
  input  logic [NEED_W-1:0]    need,
  output logic [NUM_SLOTS-1:0] pick,
  output logic [CNT_W-1:0]     free_total
);

  // below[s] = number of free slots with index lower than s
  logic [CNT_W-1:0] below [NUM_SLOTS+1];

  assign below[0] = '0;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pick
    assign below[s+1] = below[s] + CNT_W'(free_map[s]);
    assign pick[s]    = free_map[s] && (CMP_W'(below[s]) < CMP_W'(need));
  end

  assign free_total = below[NUM_SLOTS];

endmodule

// File: rtl/warp_slot_alloc.sv
module warp_slot_alloc
  import warp_alloc_pkg::*;
#(
  parameter int NUM_SLOTS    = 64,
  parameter int WARP_THREADS = 32,
  parameter int MAX_THREADS  = 1024,
  parameter int ID_W         = 6,
  parameter int THR_W        = 12,
  localparam int CNT_W       = $clog2(NUM_SLOTS + 1),
  localparam int NEED_W      = THR_W + 1,
  localparam int CMP_W       = (NEED_W > CNT_W) ? NEED_W : CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adm_valid,
  output logic                 adm_ready,
  input  logic [ID_W-1:0]      adm_id,
  input  logic [THR_W-1:0]     adm_threads,
  input  logic                 cmp_valid,
  input  logic [ID_W-1:0]      cmp_id,
  output logic                 rsp_valid,
  output logic                 rsp_grant,
  output logic [NUM_SLOTS-1:0] rsp_mask,
  output logic [CNT_W-1:0]     free_count
);

  // held request
  logic              pend_v;
  logic [ID_W-1:0]   pend_id;
  logic [THR_W-1:0]  pend_thr;

  logic [NUM_SLOTS-1:0] busy_map;
  logic [NUM_SLOTS-1:0] clr_hit;
  logic [NUM_SLOTS-1:0] pick;
  logic [NUM_SLOTS-1:0] grant_mask;
  logic [CNT_W-1:0]     free_total;
  logic [NEED_W-1:0]    need;
  logic                 bad_size;
  logic                 fits;
  alloc_dec_e           dec;

  logic                 rsp_valid_q;
  logic                 rsp_grant_q;
  logic [NUM_SLOTS-1:0] rsp_mask_q;
  logic [CNT_W-1:0]     free_q;

  assign adm_ready = !pend_v;

  // warps needed: ceiling division by the warp width
  assign need = ({1'b0, pend_thr} + NEED_W'(WARP_THREADS - 1)) / NEED_W'(WARP_THREADS);
  assign bad_size = (pend_thr == '0) || (pend_thr > THR_W'(MAX_THREADS));
  assign fits     = CMP_W'(need) <= CMP_W'(free_total);

  always_comb begin
    if (!pend_v)       dec = DEC_IDLE;
    else if (bad_size) dec = DEC_REJECT;
    else if (fits)     dec = DEC_GRANT;
    else               dec = DEC_WAIT;
  end

  assign grant_mask = (dec == DEC_GRANT) ? pick : '0;

  warp_slot_picker #(
    .NUM_SLOTS (NUM_SLOTS),
    .NEED_W    (NEED_W)
  ) u_picker (
    .free_map   (~busy_map),
    .need       (need),
    .pick       (pick),
    .free_total (free_total)
  );

  warp_slot_table #(
    .NUM_SLOTS (NUM_SLOTS),
    .ID_W      (ID_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (dec == DEC_GRANT),
    .set_mask (grant_mask),
    .set_id   (pend_id),
    .clr_en   (cmp_valid),
    .clr_id   (cmp_id),
    .busy     (busy_map),
    .clr_hit  (clr_hit)
  );

  // request holding register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_id  <= '0;
      pend_thr <= '0;
    end else if (adm_valid && adm_ready) begin
      pend_v   <= 1'b1;
      pend_id  <= adm_id;
      pend_thr <= adm_threads;
    end else if (dec == DEC_GRANT || dec == DEC_REJECT) begin
      pend_v   <= 1'b0;
    end
  end

  // response pulse and running free count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_grant_q <= 1'b0;
      rsp_mask_q  <= '0;
      free_q      <= CNT_W'(NUM_SLOTS);
    end else begin
      rsp_valid_q <= (dec == DEC_GRANT) || (dec == DEC_REJECT);
      rsp_grant_q <= (dec == DEC_GRANT);
      rsp_mask_q  <= grant_mask;
      free_q      <= free_q - CNT_W'($countones(grant_mask)) + CNT_W'($countones(clr_hit));
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_grant  = rsp_grant_q;
  assign rsp_mask   = rsp_mask_q;
  assign free_count = free_q;

endmodule

// File: rtl/warp_slot_alloc_chk.sv
module warp_slot_alloc_chk #(
  parameter int NUM_SLOTS = 64,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 adm_ready,
  input logic                 rsp_valid,
  input logic                 rsp_grant,
  input logic [NUM_SLOTS-1:0] rsp_mask,
  input logic [CNT_W-1:0]     free_count,
  input logic [NUM_SLOTS-1:0] busy
);

  AST_FREE_MATCHES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    free_count == CNT_W'(NUM_SLOTS - $countones(busy))); // R9

  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> (($past(busy) & rsp_mask) == '0)); // R3

  AST_GRANT_NOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> ((rsp_mask & ~busy) == '0)); // R10

  AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> (rsp_mask == '0)); // R5

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11

  AST_READY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> adm_ready); // R11

endmodule

bind warp_slot_alloc warp_slot_alloc_chk #(
  .NUM_SLOTS (NUM_SLOTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adm_ready  (adm_ready),
  .rsp_valid  (rsp_valid),
  .rsp_grant  (rsp_grant),
  .rsp_mask   (rsp_mask),
  .free_count (free_count),
  .busy       (busy_map)
);

// File: tb/warp_slot_alloc_tb.sv
`timescale 1ns/1ps
module warp_slot_alloc_tb;

  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adm_valid = 1'b0;
  logic          adm_ready;
  logic [5:0]    adm_id = '0;
  logic [11:0]   adm_threads = '0;
  logic          cmp_valid = 1'b0;
  logic [5:0]    cmp_id = '0;
  logic          rsp_valid;
  logic          rsp_grant;
  logic [NS-1:0] rsp_mask;
  logic [6:0]    free_count;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;

  always #2 clk = ~clk;  // 250 MHz

  warp_slot_alloc u_dut (
    .clk (clk), .rst_n (rst_n),
    .adm_valid (adm_valid), .adm_ready (adm_ready),
    .adm_id (adm_id), .adm_threads (adm_threads),
    .cmp_valid (cmp_valid), .cmp_id (cmp_id),
    .rsp_valid (rsp_valid), .rsp_grant (rsp_grant),
    .rsp_mask (rsp_mask), .free_count (free_count)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_pend;
  int          m_id, m_thr;
  bit          m_busy [NS];
  int          m_owner [NS];
  bit          m_rspv, m_grant;
  logic [NS-1:0] m_mask, m_clr, m_pick;
  int          m_free, m_need, m_nfree;
  bit          m_acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_rspv = 0; m_grant = 0; m_mask = '0; m_free = NS;
      for (int i = 0; i < NS; i++) begin m_busy[i] = 0; m_owner[i] = 0; end
    end else begin
      m_clr = '0; m_pick = '0;
      for (int i = 0; i < NS; i++)
        if (cmp_valid && m_busy[i] && m_owner[i] == int'(cmp_id)) m_clr[i] = 1'b1;
      m_acc = adm_valid && !m_pend;
      m_rspv = 0; m_grant = 0; m_mask = '0;
      if (m_pend) begin
        if (m_thr == 0 || m_thr > 1024) begin
          m_rspv = 1; m_pend = 0;
        end else begin
          m_need = (m_thr + 31) / 32;
          m_nfree = 0;
          for (int i = 0; i < NS; i++) if (!m_busy[i]) m_nfree++;
          if (m_need <= m_nfree) begin
            for (int i = 0; i < NS; i++)
              if (!m_busy[i] && m_need > 0) begin m_pick[i] = 1'b1; m_need--; end
            m_rspv = 1; m_grant = 1; m_mask = m_pick; m_pend = 0;
          end
        end
      end
      for (int i = 0; i < NS; i++) begin
        if (m_clr[i]) m_busy[i] = 0;
        if (m_pick[i]) begin m_busy[i] = 1; m_owner[i] = m_id; end
      end
      if (m_acc) begin m_pend = 1; m_id = int'(adm_id); m_thr = int'(adm_threads); end
      m_free = 0;
      for (int i = 0; i < NS; i++) if (!m_busy[i]) m_free++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(adm_ready == !m_pend, "R3 adm_ready", adm_ready, !m_pend);
      check(rsp_valid == m_rspv, "R11 rsp_valid", rsp_valid, m_rspv);
      if (m_rspv) begin
        check(rsp_grant == m_grant, "R5 rsp_grant", rsp_grant, m_grant);
        check(rsp_mask == m_mask, "R4 rsp_mask", rsp_mask, m_mask);
      end
      check(int'(free_count) == m_free, "R9 free_count", free_count, m_free);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic admit(input int id, input int thr);
    @(negedge clk);
    while (!adm_ready) @(negedge clk);
    adm_valid = 1'b1; adm_id = 6'(id); adm_threads = 12'(thr);
    @(negedge clk);
    adm_valid = 1'b0;
  endtask

  task automatic finish_blk(input int id);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_id = 6'(id);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // after admit returns we sit in cycle c+1; response shows in c+2
  task automatic expect_rsp(input string tag, input bit g, input logic [NS-1:0] mask);
    @(negedge clk);
    check(rsp_valid == 1'b1, tag, rsp_valid, 1);
    check(rsp_grant == g, tag, rsp_grant, g);
    check(rsp_mask == mask, tag, rsp_mask, mask);
  endtask

  logic [6:0] f_before;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R1 reset state
    check(free_count == 7'd64, "R1 free_count", free_count, 64);
    check(adm_ready == 1'b1, "R1 adm_ready", adm_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);

    admit(1, 128); expect_rsp("R2 128 threads", 1, 64'hF);
    admit(2, 128); expect_rsp("R10 second block", 1, 64'hF0);
    admit(3, 33);  expect_rsp("R2 33 threads", 1, 64'h300);
    admit(4, 0);   expect_rsp("R6 zero threads", 0, '0);
    admit(5, 1025); expect_rsp("R5 oversize", 0, '0);
    admit(6, 1024); expect_rsp("R2 1024 threads", 1, {22'd0, 32'hFFFF_FFFF, 10'd0});
    @(negedge clk);
    check(free_count == 7'd22, "R10 occupancy", free_count, 22);

    finish_blk(2);
    check(free_count == 7'd26, "R7 release", free_count, 26);
    finish_blk(40);
    check(free_count == 7'd26, "R8 unknown id", free_count, 26);

    admit(7, 40); expect_rsp("R4 lowest free", 1, 64'h30);

    // R3 / R12: too large, held until block 6 leaves
    admit(8, 1024);
    repeat (5) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R3 held no rsp", rsp_valid, 0);
      check(adm_ready == 1'b0, "R3 held not ready", adm_ready, 0);
      check(free_count == 7'd24, "R3 held no take", free_count, 24);
    end
    cmp_valid = 1'b1; cmp_id = 6'd6;
    @(negedge clk);
    cmp_valid = 1'b0;
    check(rsp_valid == 1'b0, "R12 not before release", rsp_valid, 0);
    @(negedge clk);
    check(rsp_valid && rsp_grant, "R12 retried grant", rsp_valid, 1);
    check(rsp_mask == {24'd0, 30'h3FFF_FFFF, 10'h0C0}, "R12 mask", rsp_mask,
          {24'd0, 30'h3FFF_FFFF, 10'h0C0});

    // R9: grant and release in the same cycle
    @(negedge clk);
    f_before = free_count;
    adm_valid = 1'b1; adm_id = 6'd9; adm_threads = 12'd64;
    @(negedge clk);
    adm_valid = 1'b0;
    cmp_valid = 1'b1; cmp_id = 6'd1;
    @(negedge clk);
    cmp_valid = 1'b0;
    check(rsp_valid && rsp_grant, "R9 grant", rsp_valid, 1);
    check(rsp_mask == (64'h3 << 40), "R9 no reuse of released", rsp_mask, 64'h3 << 40);
    check(free_count == f_before - 7'd2 + 7'd4, "R9 count", free_count, f_before - 7'd2 + 7'd4);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 pulse width", rsp_valid, 0);

    admit(10, 31); expect_rsp("R4 reuse low slot", 1, 64'h1);

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule